// File: doc/BRIEF.md
# Branch Target Mode Decoder

This block works out where instruction fetch goes next once a branch has been resolved. Its inputs are the address of the branch, the branch's encoded target field, the value of its register operand and a flag that says whether the branch is taken. Its outputs are the next fetch address and a code for how that address was formed. The top four bits of the target field are read as a signed selector. A value of 7 makes the branch register-indirect. A value of -8 sends fetch to a microcode entry point. Any other value makes the branch relative, and the selector bits then also form the top of the displacement.

Every instruction is five bytes long, so a relative displacement counts instructions rather than bytes. The target is built as one three-operand sum, pc + 4·d + d, instead of a general multiplier. With the default 17-bit field, relative branches reach about ±280 KB. The result can be presented combinationally or through one output register stage, chosen by a parameter. A separate flag marks microcode entries so that a downstream sequencer can capture the address.

Top module: `btd_branch_target`

## Requirements
- R1: When the branch is taken and the selector `tgt_field[16:13]`, read as a signed value, lies in -7..+6, `mode` is 1 (relative).
- R2: In relative mode, `next_pc` equals `pc` plus five times the sign-extended 17-bit `tgt_field`, modulo 2^32.
- R3: When the branch is taken and the selector is 7 (`4'b0111`), `mode` is 2 (register) and `next_pc` equals `reg_val`.
- R4: When the branch is taken and the selector is -8 (`4'b1000`), `mode` is 3 (microcode) and `next_pc` is `tgt_field[12:0]` zero-extended to 32 bits.
- R5: When `taken` is low, `mode` is 0 (sequential) and `next_pc` equals `pc + 5`, whatever the target field and register operand hold.
- R6: `ucode_hit` is high exactly when `out_valid` is high and `mode` is 3.
- R7: With the output register on (the default), the result of an input presented with `in_valid` high appears, with `out_valid` high, one clock later. A cycle with `in_valid` low drops `out_valid` and leaves `next_pc` and `mode` unchanged.
- R8: While reset is held, and in the first cycle after it, `out_valid`, `ucode_hit`, `mode` and `next_pc` are all zero.
- R9: The relative range extremes are reached exactly: selector -7 with zero low bits gives `pc - 286720`, and selector +6 with all low bits set gives `pc + 286715`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry a resolved branch this cycle |
| taken | input | 1 | Branch condition outcome |
| pc | input | 32 | Address of the branch instruction |
| tgt_field | input | 17 | Encoded target: selector in bits 16:13 |
| reg_val | input | 32 | Register operand for indirect branches |
| out_valid | output | 1 | `next_pc` and `mode` hold a fresh result |
| next_pc | output | 32 | Resolved next fetch address |
| mode | output | 2 | 0 sequential, 1 relative, 2 register, 3 microcode |
| ucode_hit | output | 1 | Result is a microcode entry address |

## Verification
With the output register on, every result appears exactly one clock after the cycle in which its inputs were held with `in_valid` high. Inputs are driven on the falling edge. The driver puts the expected address, mode and flag into a queue when it drives them. A monitor samples shortly after each rising edge and takes the oldest expected item whenever `out_valid` is high. So each comparison lines up with the one-cycle latency, and a result that comes late, comes twice or never comes shows up as a queue mismatch or as a queue that is not empty at the end. The idle-cycle hold and the reset state are sampled the same way, one rising edge after the stimulus that causes them.

// File: rtl/btd_pkg.sv
package btd_pkg;

  // Instruction size in bytes; relative displacements count instructions.
  localparam int INSN_BYTES = 5;

  // Width of the selector held at the top of the target field.
  localparam int SEL_W = 4;

  // Selector codes that do not mean a relative branch.
  localparam logic [SEL_W-1:0] SEL_REG   = 4'b0111;  // +7
  localparam logic [SEL_W-1:0] SEL_UCODE = 4'b1000;  // -8

  typedef enum logic [1:0] {
    BR_SEQ   = 2'd0,
    BR_REL   = 2'd1,
    BR_REG   = 2'd2,
    BR_UCODE = 2'd3
  } br_mode_e;

endpackage

// File: rtl/btd_mode_decode.sv
module btd_mode_decode
  import btd_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             taken,
  output br_mode_e         mode
);

  always_comb begin
    if (!taken) begin
      mode = BR_SEQ;
    end else begin
      unique case (sel)
        SEL_REG:   mode = BR_REG;
        SEL_UCODE: mode = BR_UCODE;
        default:   mode = BR_REL;
      endcase
    end
  end

endmodule

// File: rtl/btd_rel_adder.sv
module btd_rel_adder #(
  parameter int AW = 32,
  parameter int DW = 17
) (
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] sum
);

  localparam int EXT_W = AW - DW;

  logic [AW-1:0] disp_x;
  logic [AW-1:0] disp_x4;

  always_comb begin
    disp_x  = {{EXT_W{disp[DW-1]}}, disp};
    disp_x4 = disp_x << 2;
    // One three-operand sum: pc + 4d + d = pc + 5d.
    sum     = pc + disp_x4 + disp_x;
  end

endmodule

// File: rtl/btd_target_mux.sv
module btd_target_mux
  import btd_pkg::*;
#(
  parameter int AW = 32,
  parameter int UW = 13
) (
  input  br_mode_e      mode,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] rel_sum,
  input  logic [AW-1:0] reg_val,
  input  logic [UW-1:0] ucode_bits,
  output logic [AW-1:0] next_pc
);

  localparam int ZPAD_W = AW - UW;

  logic [AW-1:0] seq_pc;
  logic [AW-1:0] ucode_pc;

  always_comb begin
    seq_pc   = pc + AW'(INSN_BYTES);
    ucode_pc = {{ZPAD_W{1'b0}}, ucode_bits};
    unique case (mode)
      BR_SEQ:   next_pc = seq_pc;
      BR_REL:   next_pc = rel_sum;
      BR_REG:   next_pc = reg_val;
      BR_UCODE: next_pc = ucode_pc;
      default:  next_pc = seq_pc;
    endcase
  end

endmodule

// File: rtl/btd_branch_target.sv
module btd_branch_target
  import btd_pkg::*;
#(
  parameter int AW      = 32,
  parameter int TW      = 17,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          taken,
  input  logic [AW-1:0] pc,
  input  logic [TW-1:0] tgt_field,
  input  logic [AW-1:0] reg_val,
  output logic          out_valid,
  output logic [AW-1:0] next_pc,
  output logic [1:0]    mode,
  output logic          ucode_hit
);

  localparam int UW = TW - SEL_W;

  br_mode_e      mode_c;
  logic [AW-1:0] rel_sum;
  logic [AW-1:0] next_c;
  logic          hit_c;

  btd_mode_decode u_dec (
    .sel   (tgt_field[TW-1 -: SEL_W]),
    .taken (taken),
    .mode  (mode_c)
  );

  btd_rel_adder #(.AW(AW), .DW(TW)) u_add (
    .pc   (pc),
    .disp (tgt_field),
    .sum  (rel_sum)
  );

  btd_target_mux #(.AW(AW), .UW(UW)) u_mux (
    .mode       (mode_c),
    .pc         (pc),
    .rel_sum    (rel_sum),
    .reg_val    (reg_val),
    .ucode_bits (tgt_field[UW-1:0]),
    .next_pc    (next_c)
  );

  assign hit_c = in_valid && (mode_c == BR_UCODE);

  generate
    if (REG_OUT) begin : g_reg
      logic          valid_d, valid_q;
      logic          hit_d,   hit_q;
      logic [AW-1:0] pc_d,    pc_q;
      br_mode_e      mode_d,  mode_q;

      // Next-state: data words load only when in_valid is high.
      always_comb begin
        valid_d = in_valid;
        hit_d   = hit_c;
        pc_d    = pc_q;
        mode_d  = mode_q;
        if (in_valid) begin
          pc_d   = next_c;
          mode_d = mode_c;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          hit_q   <= 1'b0;
          pc_q    <= '0;
          mode_q  <= BR_SEQ;
        end else begin
          valid_q <= valid_d;
          hit_q   <= hit_d;
          pc_q    <= pc_d;
          mode_q  <= mode_d;
        end
      end

      assign out_valid = valid_q;
      assign ucode_hit = hit_q;
      assign next_pc   = pc_q;
      assign mode      = mode_q;
    end else begin : g_comb
      assign out_valid = in_valid;
      assign ucode_hit = hit_c;
      assign next_pc   = next_c;
      assign mode      = mode_c;
    end
  endgenerate

endmodule

// File: rtl/btd_branch_target_chk.sv
module btd_branch_target_chk #(
  parameter int AW      = 32,
  parameter int TW      = 17,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          taken,
  input logic [AW-1:0] pc,
  input logic [TW-1:0] tgt_field,
  input logic [AW-1:0] reg_val,
  input logic          out_valid,
  input logic [AW-1:0] next_pc,
  input logic [1:0]    mode,
  input logic          ucode_hit
);

  localparam int UW = TW - 4;

  logic sel_reg, sel_uc;
  assign sel_reg = (tgt_field[TW-1 -: 4] == 4'b0111);
  assign sel_uc  = (tgt_field[TW-1 -: 4] == 4'b1000);

  // R6: flag agrees with the reported mode.
  p_hit_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_hit == (out_valid && (mode == 2'd3)));

  generate
    if (REG_OUT) begin : g_seq
      // R5
      p_seq_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !taken) |=> (mode == 2'd0) && (next_pc == $past(pc) + AW'(5)));
      // R3
      p_reg_ind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && taken && sel_reg) |=> (mode == 2'd2) && (next_pc == $past(reg_val)));
      // R4
      p_ucode_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && taken && sel_uc) |=>
          (mode == 2'd3) && (next_pc == AW'($past(tgt_field[UW-1:0]))));
      // R1
      p_rel_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && taken && !sel_reg && !sel_uc) |=> (mode == 2'd1));
      // R7
      p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(next_pc) && $stable(mode));
    end else begin : g_comb
      p_seq_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !taken) |-> (mode == 2'd0) && (next_pc == pc + AW'(5)));
      p_reg_ind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && taken && sel_reg) |-> (mode == 2'd2) && (next_pc == reg_val));
    end
  endgenerate

endmodule

bind btd_branch_target btd_branch_target_chk #(
  .AW(AW), .TW(TW), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/sim_btd_branch_target.sv
`timescale 1ns/1ps
module sim_btd_branch_target;

  localparam int AW = 32;
  localparam int TW = 17;

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    md;
    logic          hit;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          taken;
  logic [AW-1:0] pc;
  logic [TW-1:0] tgt_field;
  logic [AW-1:0] reg_val;
  logic          out_valid;
  logic [AW-1:0] next_pc;
  logic [1:0]    mode;
  logic          ucode_hit;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  btd_branch_target u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .taken(taken),
    .pc(pc), .tgt_field(tgt_field), .reg_val(reg_val),
    .out_valid(out_valid), .next_pc(next_pc), .mode(mode), .ucode_hit(ucode_hit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected result from the requirements.
  function automatic exp_t model(input logic [AW-1:0] p, input logic [TW-1:0] f,
                                 input logic [AW-1:0] r, input logic tk, input string req);
    exp_t e;
    int   d;
    e.req = req;
    e.hit = 1'b0;
    if (!tk) begin
      e.md = 2'd0; e.addr = p + 32'd5;
    end else if (f[16:13] == 4'b0111) begin
      e.md = 2'd2; e.addr = r;
    end else if (f[16:13] == 4'b1000) begin
      e.md = 2'd3; e.addr = {19'd0, f[12:0]}; e.hit = 1'b1;
    end else begin
      d = int'($signed(f));
      e.md = 2'd1; e.addr = p + 32'(d * 5);
    end
    return e;
  endfunction

  task automatic drive(input logic [AW-1:0] p, input logic [TW-1:0] f,
                       input logic [AW-1:0] r, input logic tk, input string req);
    @(negedge clk);
    in_valid = 1'b1; taken = tk; pc = p; tgt_field = f; reg_val = r;
    sb_q.push_back(model(p, f, r, tk, req));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      taken = 1'b1; pc = pc + 32'h40; tgt_field = 17'h0_1234 ^ 17'(i); reg_val = ~reg_val;
    end
  endtask

  // Monitor: pops and compares one expected item per valid output.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && out_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7", "unexpected out_valid", {31'd0, out_valid}, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(next_pc == e.addr, e.req, "next_pc", next_pc, e.addr);
          check(mode == e.md, e.req, "mode", {30'd0, mode}, {30'd0, e.md});
          check(ucode_hit == e.hit, "R6", "ucode_hit", {31'd0, ucode_hit}, {31'd0, e.hit});
        end
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held;
    rst_n = 1'b0; in_valid = 1'b0; taken = 1'b0;
    pc = '0; tgt_field = '0; reg_val = '0;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R8", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    check(ucode_hit == 1'b0, "R8", "ucode_hit in reset", {31'd0, ucode_hit}, 32'd0);
    check(next_pc == '0, "R8", "next_pc in reset", next_pc, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(out_valid == 1'b0 && mode == 2'd0, "R8", "state after release",
          {30'd0, mode}, 32'd0);

    // R5: not taken, field contents ignored
    drive(32'h0000_1000, 17'h1_0ABC, 32'hDEAD_BEEF, 1'b0, "R5");
    drive(32'h0000_2000, {4'b0111, 13'h0055}, 32'h1111_2222, 1'b0, "R5");
    // R1/R2: relative, positive, negative, zero
    drive(32'h0001_0000, 17'h0_0003, 32'h0, 1'b1, "R2");
    drive(32'h0001_0000, 17'h1_FFFF, 32'h0, 1'b1, "R2");
    drive(32'h0004_0000, 17'h0_0000, 32'h0, 1'b1, "R1");
    drive(32'h0004_0000, {4'b1010, 13'h0123}, 32'h0, 1'b1, "R1");
    // R9: range extremes
    drive(32'h0100_0000, {4'b1001, 13'h0000}, 32'h0, 1'b1, "R9");
    drive(32'h0100_0000, {4'b0110, 13'h1FFF}, 32'h0, 1'b1, "R9");
    // R2: wrap modulo 2^32
    drive(32'hFFFF_FFFE, 17'h0_0004, 32'h0, 1'b1, "R2");
    // R3: register indirect
    drive(32'h0000_3000, {4'b0111, 13'h1FFF}, 32'hCAFE_0010, 1'b1, "R3");
    // R4: microcode entry
    drive(32'h0000_4000, {4'b1000, 13'h1ABC}, 32'h5555_5555, 1'b1, "R4");
    drive(32'h8000_0000, {4'b1000, 13'h0001}, 32'h0, 1'b1, "R4");
    idle(1);
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R7", "out_valid after idle", {31'd0, out_valid}, 32'd0);
    check(ucode_hit == 1'b0, "R6", "ucode_hit after idle", {31'd0, ucode_hit}, 32'd0);
    held = next_pc;
    check(held == 32'h0000_0001, "R7", "held value", held, 32'h0000_0001);
    idle(3);
    @(posedge clk); #1;
    check(next_pc == held && mode == 2'd3 && !out_valid, "R7", "hold over idle",
          next_pc, held);

    // mixed stream
    for (int i = 0; i < 40; i++) begin
      logic [TW-1:0] f;
      f = 17'((i * 32'h2F3D7) ^ 32'h0_5A5A);
      drive(32'h0200_0000 + 32'(i * 37), f, 32'(i * 32'h0101_0101), (i % 3) != 0,
            (f[16:13] == 4'b0111) ? "R3" : (f[16:13] == 4'b1000) ? "R4" : "R2");
    end
    idle(2);
    repeat (2) @(posedge clk);
    #1;
    check(sb_q.size() == 0, "R7", "results outstanding", 32'(sb_q.size()), 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule